// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Flag Register

This block is the data path of a small accumulator-based processor core. Each cycle it receives an operation code, the accumulator value and one operand byte, and produces the result byte combinationally in the same cycle. It also computes a new status byte, which is captured into a flag register on the next rising clock edge. The carry flag held in that register is the carry or borrow input for the operations that use one.

Each class of operation updates its own subset of the flags by fixed rules. Logic operations force the carry and half-carry bits. Rotates touch only carry. Compare reports the ordering of its two operands through carry and zero and leaves the accumulator unchanged. A separate wide adder adds two register pairs, and that operation changes only carry. Instruction fetch, decode, the register file and memory access sit outside the block: the surrounding core routes the result to wherever it belongs.

Top module: `acc_alu`

## Requirements
- R1: The flag byte has sign at bit 7, zero at bit 6, half-carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 always read 0. Reset clears the whole byte. Parity is 1 when the result has an even number of ones.
- R2: Add (code 1) and add-with-carry (code 2) return acc + operand (+ carry for code 2) modulo 256. They update all five flags. Carry is the carry out of bit 7, and half-carry is the carry out of bit 3.
- R3: Subtract (code 3) and subtract-with-borrow (code 4) return acc − operand (− carry for code 4) modulo 256 in two's complement. Carry is set when a borrow occurs. Half-carry is the carry out of bit 3 of acc + ~operand + (1 for code 3, or the inverted carry for code 4). Sign, zero and parity follow the result.
- R4: Increment (code 5) and decrement (code 6) return operand ± 1 modulo 256. They update sign, zero, parity and half-carry, and leave carry unchanged. For increment, half-carry is set when operand[3:0] is 15. For decrement, it is set when operand[3:0] is not 0.
- R5: AND (code 7) returns acc & operand. It updates sign, zero and parity, clears carry and sets half-carry.
- R6: OR (code 8) and XOR (code 9) return the bitwise result. They update sign, zero and parity, and clear both carry and half-carry.
- R7: The rotates change only carry:
  - Code 10 rotates acc left, and bit 7 goes to both bit 0 and carry.
  - Code 11 rotates right, and bit 0 goes to both bit 7 and carry.
  - Code 12 rotates left through carry.
  - Code 13 rotates right through carry.
- R8: Compare (code 14) returns acc unchanged and sets the flags as the subtraction acc − operand would. So carry is set when acc < operand (unsigned), zero is set when they are equal, and both are clear when acc is greater.
- R9: Complement (code 15) returns ~acc and leaves every flag unchanged.
- R10: Code 16 inverts carry and code 17 sets carry. Both leave the other flags unchanged and return acc.
- R11: pair_res_o always equals pair_a_i + pair_b_i modulo 2^16. Pair add (code 18) sets carry to the carry out of bit 15, changes no other flag and returns acc.
- R12: Code 0 and every code from 19 to 31 return acc and leave the flags unchanged.
- R13: res_o depends only on the current inputs and the held flags. The flag register takes its new value at the first rising clock edge at which the operation is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the flag register |
| op_i | input | 5 | Operation code |
| acc_i | input | W | Accumulator value |
| opnd_i | input | W | Operand byte |
| pair_a_i | input | 2W | First register pair for the wide add |
| pair_b_i | input | 2W | Second register pair for the wide add |
| res_o | output | W | Result byte |
| pair_res_o | output | 2W | Wide sum |
| flags_o | output | 8 | Registered flag byte |

## Verification
The bench builds the block with W = 8, so the wide path is 16 bits. At that width the sign boundary (0x7F/0x80), the nibble boundary (0x0F/0x10), the wrap points 0xFF/0x00 and the 0xFFFF overflow of the pair add are all reached with a handful of directed values. Thousands of random operations with random codes from 0 to 20 then cover every operation code against every state of the held carry, and also reach the unused codes.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    op_i,
  input  logic [W-1:0]  acc_i,
  input  logic [W-1:0]  opnd_i,
  input  logic [2*W-1:0] pair_a_i,
  input  logic [2*W-1:0] pair_b_i,
  output logic [W-1:0]  res_o,
  output logic [2*W-1:0] pair_res_o,
  output logic [7:0]    flags_o
);
  localparam int PW = 2 * W;
  localparam int FS = 7, FZ = 6, FH = 4, FP = 2, FC = 0;

  localparam logic [4:0] OP_NOP = 5'd0,  OP_ADD = 5'd1,  OP_ADC = 5'd2,
                         OP_SUB = 5'd3,  OP_SBB = 5'd4,  OP_INC = 5'd5,
                         OP_DEC = 5'd6,  OP_AND = 5'd7,  OP_OR  = 5'd8,
                         OP_XOR = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
                         OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMP = 5'd14,
                         OP_CPL = 5'd15, OP_CMC = 5'd16, OP_STC = 5'd17,
                         OP_PAD = 5'd18;

  logic [7:0]   flags_q, flags_d;
  logic         cy;
  logic [W-1:0] ax, ay;
  logic         acin;
  logic [W:0]   sum;
  logic [4:0]   lo;
  logic [PW:0]  psum;

  assign cy = flags_q[FC];

  always_comb begin
    ax   = acc_i;
    ay   = opnd_i;
    acin = 1'b0;
    unique case (op_i)
      OP_ADC:         acin = cy;
      OP_SUB, OP_CMP: begin ay = ~opnd_i; acin = 1'b1; end
      OP_SBB:         begin ay = ~opnd_i; acin = ~cy;  end
      OP_INC:         begin ax = opnd_i; ay = '0; acin = 1'b1; end
      OP_DEC:         begin ax = opnd_i; ay = '1; acin = 1'b0; end
      default: ;
    endcase
  end

  assign sum  = {1'b0, ax} + {1'b0, ay} + {{W{1'b0}}, acin};
  assign lo   = {1'b0, ax[3:0]} + {1'b0, ay[3:0]} + {4'd0, acin};
  assign psum = {1'b0, pair_a_i} + {1'b0, pair_b_i};
  assign pair_res_o = psum[PW-1:0];

  function automatic logic [7:0] pack(input logic [W-1:0] r, input logic h, input logic c);
    logic [7:0] f;
    f     = '0;
    f[FS] = r[W-1];
    f[FZ] = (r == '0);
    f[FH] = h;
    f[FP] = ~^r;
    f[FC] = c;
    return f;
  endfunction

  always_comb begin
    res_o   = acc_i;
    flags_d = flags_q;
    unique case (op_i)
      OP_ADD, OP_ADC: begin
        res_o   = sum[W-1:0];
        flags_d = pack(sum[W-1:0], lo[4], sum[W]);
      end
      OP_SUB, OP_SBB: begin
        res_o   = sum[W-1:0];
        flags_d = pack(sum[W-1:0], lo[4], ~sum[W]);
      end
      OP_CMP: flags_d = pack(sum[W-1:0], lo[4], ~sum[W]);
      OP_INC, OP_DEC: begin
        res_o   = sum[W-1:0];
        flags_d = pack(sum[W-1:0], lo[4], cy);
      end
      OP_AND: begin
        res_o   = acc_i & opnd_i;
        flags_d = pack(acc_i & opnd_i, 1'b1, 1'b0);
      end
      OP_OR: begin
        res_o   = acc_i | opnd_i;
        flags_d = pack(acc_i | opnd_i, 1'b0, 1'b0);
      end
      OP_XOR: begin
        res_o   = acc_i ^ opnd_i;
        flags_d = pack(acc_i ^ opnd_i, 1'b0, 1'b0);
      end
      OP_RLC: begin
        res_o       = {acc_i[W-2:0], acc_i[W-1]};
        flags_d[FC] = acc_i[W-1];
      end
      OP_RRC: begin
        res_o       = {acc_i[0], acc_i[W-1:1]};
        flags_d[FC] = acc_i[0];
      end
      OP_RAL: begin
        res_o       = {acc_i[W-2:0], cy};
        flags_d[FC] = acc_i[W-1];
      end
      OP_RAR: begin
        res_o       = {cy, acc_i[W-1:1]};
        flags_d[FC] = acc_i[0];
      end
      OP_CPL: res_o = ~acc_i;
      OP_CMC: flags_d[FC] = ~cy;
      OP_STC: flags_d[FC] = 1'b1;
      OP_PAD: flags_d[FC] = psum[PW];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  assert_and_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_AND) |=> (flags_o[FC] == 1'b0 && flags_o[FH] == 1'b1));

  assert_or_xor_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_OR || op_i == OP_XOR) |=> (flags_o[FC] == 1'b0 && flags_o[FH] == 1'b0));

  assert_rotate_only_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= OP_RLC && op_i <= OP_RAR) |=> (flags_o[7:1] == $past(flags_o[7:1])));

  assert_cmp_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP && acc_i == opnd_i) |=> (flags_o[FZ] && !flags_o[FC]));

  assert_cmp_keeps_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP) |-> (res_o == acc_i));

  assert_cpl_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CPL) |=> $stable(flags_o));

  assert_cmc_toggles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMC) |=> (flags_o[FC] != $past(flags_o[FC])));

  assert_pair_only_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PAD) |=> (flags_o[7:1] == $past(flags_o[7:1])));

  assert_incdec_keep_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_INC || op_i == OP_DEC) |=> (flags_o[FC] == $past(flags_o[FC])));

  assert_spare_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[5] == 1'b0 && flags_o[3] == 1'b0 && flags_o[1] == 1'b0));

endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op_i = '0;
  logic [7:0]  acc_i = '0, opnd_i = '0;
  logic [15:0] pair_a_i = '0, pair_b_i = '0;
  logic [7:0]  res_o;
  logic [15:0] pair_res_o;
  logic [7:0]  flags_o;

  int total = 0;
  int bad = 0;
  int fmodel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .pair_a_i(pair_a_i), .pair_b_i(pair_b_i),
    .res_o(res_o), .pair_res_o(pair_res_o), .flags_o(flags_o)
  );

  function automatic int mkflags(input int r, input int h, input int c);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (r >> i) & 1;
    return (((r >> 7) & 1) << 7) | ((r == 0) << 6) | ((h & 1) << 4) |
           (((n % 2) == 0) << 2) | (c & 1);
  endfunction

  function automatic void model(input int op, input int a, input int b,
                                input int pa, input int pb, input int fl,
                                output int r, output int f);
    int c = fl & 1;
    r = a;
    f = fl;
    case (op)
      1, 2: begin
        int ci = (op == 2) ? c : 0;
        r = (a + b + ci) & 255;
        f = mkflags(r, ((a & 15) + (b & 15) + ci) > 15, (a + b + ci) > 255);
      end
      3, 4, 14: begin
        int bi = (op == 4) ? c : 0;
        int d = (a - b - bi) & 255;
        f = mkflags(d, ((a & 15) + ((~b) & 15) + (1 - bi)) > 15, a < (b + bi));
        if (op != 14) r = d;
      end
      5: begin r = (b + 1) & 255; f = mkflags(r, (b & 15) == 15, c); end
      6: begin r = (b - 1) & 255; f = mkflags(r, (b & 15) != 0, c); end
      7: begin r = a & b; f = mkflags(r, 1, 0); end
      8: begin r = a | b; f = mkflags(r, 0, 0); end
      9: begin r = a ^ b; f = mkflags(r, 0, 0); end
      10: begin r = ((a << 1) | (a >> 7)) & 255; f = (fl & 254) | (a >> 7); end
      11: begin r = (a >> 1) | ((a & 1) << 7); f = (fl & 254) | (a & 1); end
      12: begin r = ((a << 1) | c) & 255; f = (fl & 254) | (a >> 7); end
      13: begin r = (a >> 1) | (c << 7); f = (fl & 254) | (a & 1); end
      15: r = (~a) & 255;
      16: f = fl ^ 1;
      17: f = fl | 1;
      18: f = (fl & 254) | ((pa + pb) > 65535);
      default: ;
    endcase
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      1, 2: return "R2";
      3, 4: return "R3";
      5, 6: return "R4";
      7: return "R5";
      8, 9: return "R6";
      10, 11, 12, 13: return "R7";
      14: return "R8";
      15: return "R9";
      16, 17: return "R10";
      18: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int op, input int a, input int b, input int pa, input int pb);
    int r, f;
    string t = tag_of(op);
    @(negedge clk);
    op_i = op[4:0]; acc_i = a[7:0]; opnd_i = b[7:0];
    pair_a_i = pa[15:0]; pair_b_i = pb[15:0];
    model(op, a, b, pa, pb, fmodel, r, f);
    #1;
    check(t, "result (R13 same cycle)", int'(res_o), r);
    check("R11", "pair sum", int'(pair_res_o), (pa + pb) & 65535);
    @(posedge clk);
    #1;
    check(t, "flags (R13 next edge)", int'(flags_o), f);
    fmodel = f;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "flags in reset", int'(flags_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    fmodel = 0;
    @(posedge clk); #1;
    check("R1", "flags after reset", int'(flags_o), 0);

    step(1, 8'h7F, 8'h01, 0, 0);
    step(1, 8'hFF, 8'h01, 0, 0);
    step(2, 8'h10, 8'h20, 0, 0);
    step(17, 8'h00, 8'h00, 0, 0);
    step(2, 8'h0E, 8'h01, 0, 0);
    step(3, 8'h10, 8'h01, 0, 0);
    step(3, 8'h00, 8'h01, 0, 0);
    step(4, 8'h05, 8'h05, 0, 0);
    step(4, 8'h50, 8'h20, 0, 0);
    step(17, 0, 0, 0, 0);
    step(5, 8'h00, 8'hFF, 0, 0);
    step(5, 8'h00, 8'h0F, 0, 0);
    step(6, 8'h00, 8'h00, 0, 0);
    step(6, 8'h00, 8'h01, 0, 0);
    step(7, 8'hF3, 8'h3C, 0, 0);
    step(7, 8'h0F, 8'hF0, 0, 0);
    step(8, 8'h81, 8'h02, 0, 0);
    step(9, 8'h5A, 8'h5A, 0, 0);
    step(17, 0, 0, 0, 0);
    step(10, 8'h81, 0, 0, 0);
    step(11, 8'h02, 0, 0, 0);
    step(12, 8'h40, 0, 0, 0);
    step(13, 8'h01, 0, 0, 0);
    step(13, 8'h02, 0, 0, 0);
    step(14, 8'h20, 8'h30, 0, 0);
    step(14, 8'h44, 8'h44, 0, 0);
    step(14, 8'h90, 8'h12, 0, 0);
    step(15, 8'hA5, 0, 0, 0);
    step(16, 0, 0, 0, 0);
    step(16, 0, 0, 0, 0);
    step(18, 8'h33, 0, 16'hFFFF, 16'h0001);
    step(18, 8'h33, 0, 16'h1234, 16'h4321);
    step(0, 8'h77, 8'h11, 0, 0);
    step(31, 8'h66, 8'h22, 0, 0);

    for (int k = 0; k < 3000; k++)
      step($urandom_range(0, 20), $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 65535), $urandom_range(0, 65535));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule